// File: doc/BRIEF.md
# Two-Source PWM Logic Combiner

This block picks two signals from the bus of generator output pins, optionally inverts each one, and merges them with a Boolean function chosen at run time. The result then takes the place of one pin of one generator. A build parameter names the instance with a letter. Instances `A`, `C` and `E` act on high-side pins, and instances `B`, `D` and `F` act on low-side pins. The pin on the other side of every generator always passes through untouched.

The pin sets are plain level signals with no flow control, so the block has no valid/ready interface. Inputs are sampled on each rising clock edge, and the full overridden pin set is presented from a register one cycle later. Every pin has exactly one flop of latency, whether or not it was replaced. This keeps the edges of replaced and passed-through pins aligned with each other.

Top module: `pwm_combo_cell`

## Requirements
- R1: Source select code k (4 bits) picks generator k/2+1, taking its high-side pin when k is even and its low-side pin when k is odd. Code 0 therefore picks generator 1 high-side and code 15 picks generator 8 low-side.
- R2: When a source's invert bit is 1, that source is complemented before combining. When the bit is 0, the source is used as is.
- R3: Function code 2'b00 gives OR, 2'b01 gives AND and 2'b10 gives XOR of the two conditioned sources.
- R4: Destination code 3'b000 disables the cell, and every output pin then equals its input pin.
- R5: Destination code d in 1..7 replaces only the pin of generator d+1 (bus bit d). Every other generator, including generator 1, passes through.
- R6: With the instance letter A, C or E the replaced pin is on the high-side bus. With B, D or F it is on the low-side bus. The opposite bus always passes through.
- R7: Function code 2'b11 is reserved. Its result is constant 0, it overrides nothing, and all pins pass through.
- R8: Outputs are registered with one clock of latency for every pin. While reset is low, both output buses read all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pwm_h_in | input | 8 | High-side pins of generators 1..8 (bit 0 = generator 1) |
| pwm_l_in | input | 8 | Low-side pins of generators 1..8 |
| src_a_sel | input | 4 | First source select |
| src_b_sel | input | 4 | Second source select |
| src_a_inv | input | 1 | Invert first source |
| src_b_inv | input | 1 | Invert second source |
| func_sel | input | 2 | Combining function |
| dest_sel | input | 3 | Destination generator, 0 = disabled |
| pwm_h_out | output | 8 | High-side pins after override, registered |
| pwm_l_out | output | 8 | Low-side pins after override, registered |

## Verification
The hardest case to reach from the ports is a result that matches the destination pin's own input value, because a correct override then looks exactly like a pass-through. The vector table therefore picks, for each function, a destination whose input bit is the opposite of the computed result, so every override flips a visible bit. All sixteen select codes are swept by looping one source onto itself through OR, so the output reproduces exactly the selected pin. A second instance built with letter B runs the same vectors to expose the low-side routing.

// File: rtl/pwm_combo_pkg.sv
package pwm_combo_pkg;
  typedef enum logic [1:0] {
    FN_OR   = 2'b00,
    FN_AND  = 2'b01,
    FN_XOR  = 2'b10,
    FN_RSVD = 2'b11
  } combo_fn_e;

  function automatic logic letter_is_high(input logic [7:0] letter);
    return (letter == "A") || (letter == "C") || (letter == "E");
  endfunction
endpackage

// File: rtl/pwm_combo_src.sv
module pwm_combo_src #(
  parameter int NGEN = 8,
  localparam int NPIN = 2 * NGEN,
  localparam int SELW = $clog2(NPIN)
) (
  input  logic [NGEN-1:0] h_in,
  input  logic [NGEN-1:0] l_in,
  input  logic [SELW-1:0] sel,
  input  logic            inv,
  output logic            bit_o
);
  logic [NPIN-1:0] flat;

  // interleave: even index = high side, odd index = low side
  for (genvar g = 0; g < NGEN; g++) begin : g_flat
    assign flat[2*g]   = h_in[g];
    assign flat[2*g+1] = l_in[g];
  end

  assign bit_o = flat[sel] ^ inv;
endmodule

// File: rtl/pwm_combo_fn.sv
module pwm_combo_fn
  import pwm_combo_pkg::*;
(
  input  logic       a,
  input  logic       b,
  input  logic [1:0] fn,
  output logic       y,
  output logic       live
);
  always_comb begin
    y    = 1'b0;
    live = 1'b1;
    case (fn)
      FN_OR:   y = a | b;
      FN_AND:  y = a & b;
      FN_XOR:  y = a ^ b;
      default: live = 1'b0;
    endcase
  end
endmodule

// File: rtl/pwm_combo_route.sv
module pwm_combo_route #(
  parameter int NGEN       = 8,
  parameter bit DRIVE_HIGH = 1'b1,
  localparam int DW        = $clog2(NGEN)
) (
  input  logic [NGEN-1:0] h_in,
  input  logic [NGEN-1:0] l_in,
  input  logic [DW-1:0]   dst,
  input  logic            live,
  input  logic            val,
  output logic [NGEN-1:0] h_out,
  output logic [NGEN-1:0] l_out
);
  logic [NGEN-1:0] near_in, near_out;

  // generator 1 (index 0) is never a destination: code 0 disables
  assign near_out[0] = near_in[0];
  for (genvar g = 1; g < NGEN; g++) begin : g_pin
    assign near_out[g] = (live && dst == DW'(g)) ? val : near_in[g];
  end

  if (DRIVE_HIGH) begin : g_high
    assign near_in = h_in;
    assign h_out   = near_out;
    assign l_out   = l_in;
  end else begin : g_low
    assign near_in = l_in;
    assign l_out   = near_out;
    assign h_out   = h_in;
  end
endmodule

// File: rtl/pwm_combo_cell.sv
module pwm_combo_cell
  import pwm_combo_pkg::*;
#(
  parameter int         NGEN    = 8,
  parameter logic [7:0] INST_ID = "A",
  localparam int        SELW    = $clog2(2 * NGEN),
  localparam int        DW      = $clog2(NGEN),
  localparam bit        DRIVE_HIGH = letter_is_high(INST_ID)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NGEN-1:0] pwm_h_in,
  input  logic [NGEN-1:0] pwm_l_in,
  input  logic [SELW-1:0] src_a_sel,
  input  logic [SELW-1:0] src_b_sel,
  input  logic            src_a_inv,
  input  logic            src_b_inv,
  input  logic [1:0]      func_sel,
  input  logic [DW-1:0]   dest_sel,
  output logic [NGEN-1:0] pwm_h_out,
  output logic [NGEN-1:0] pwm_l_out
);
  logic            a_bit, b_bit, res, fn_live;
  logic [NGEN-1:0] h_nxt, l_nxt;

  pwm_combo_src #(.NGEN(NGEN)) u_src_a (
    .h_in(pwm_h_in), .l_in(pwm_l_in), .sel(src_a_sel), .inv(src_a_inv), .bit_o(a_bit));
  pwm_combo_src #(.NGEN(NGEN)) u_src_b (
    .h_in(pwm_h_in), .l_in(pwm_l_in), .sel(src_b_sel), .inv(src_b_inv), .bit_o(b_bit));

  pwm_combo_fn u_fn (.a(a_bit), .b(b_bit), .fn(func_sel), .y(res), .live(fn_live));

  pwm_combo_route #(.NGEN(NGEN), .DRIVE_HIGH(DRIVE_HIGH)) u_route (
    .h_in(pwm_h_in), .l_in(pwm_l_in), .dst(dest_sel), .live(fn_live), .val(res),
    .h_out(h_nxt), .l_out(l_nxt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_h_out <= '0;
      pwm_l_out <= '0;
    end else begin
      pwm_h_out <= h_nxt;
      pwm_l_out <= l_nxt;
    end
  end
endmodule

// File: rtl/pwm_combo_cell_chk.sv
module pwm_combo_cell_chk #(
  parameter int NGEN       = 8,
  parameter bit DRIVE_HIGH = 1'b1,
  localparam int DW        = $clog2(NGEN)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NGEN-1:0] pwm_h_in,
  input logic [NGEN-1:0] pwm_l_in,
  input logic [1:0]      func_sel,
  input logic [DW-1:0]   dest_sel,
  input logic [NGEN-1:0] pwm_h_out,
  input logic [NGEN-1:0] pwm_l_out
);
  logic [NGEN-1:0] near_i, near_o, far_i, far_o;
  assign near_i = DRIVE_HIGH ? pwm_h_in  : pwm_l_in;
  assign near_o = DRIVE_HIGH ? pwm_h_out : pwm_l_out;
  assign far_i  = DRIVE_HIGH ? pwm_l_in  : pwm_h_in;
  assign far_o  = DRIVE_HIGH ? pwm_l_out : pwm_h_out;

  AST_DISABLED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    dest_sel == '0 |=> pwm_h_out == $past(pwm_h_in) && pwm_l_out == $past(pwm_l_in)); // R4
  AST_RESERVED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    func_sel == 2'b11 |=> pwm_h_out == $past(pwm_h_in) && pwm_l_out == $past(pwm_l_in)); // R7
  AST_FAR_SIDE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> far_o == $past(far_i)); // R6
  AST_ONE_PIN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $countones(near_o ^ $past(near_i)) <= 1); // R5
  AST_GEN1_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> near_o[0] == $past(near_i[0])); // R5
endmodule

bind pwm_combo_cell pwm_combo_cell_chk #(.NGEN(NGEN), .DRIVE_HIGH(DRIVE_HIGH)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_h_in(pwm_h_in), .pwm_l_in(pwm_l_in),
  .func_sel(func_sel), .dest_sel(dest_sel), .pwm_h_out(pwm_h_out), .pwm_l_out(pwm_l_out));

// File: tb/pwm_combo_cell_test.sv
module pwm_combo_cell_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] h_in, l_in;
  logic [3:0] sa, sb;
  logic       ia, ib;
  logic [1:0] fn;
  logic [2:0] dst;
  logic [7:0] ha_o, la_o, hb_o, lb_o;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pwm_combo_cell #(.NGEN(8), .INST_ID("A")) uut (
    .clk(clk), .rst_n(rst_n), .pwm_h_in(h_in), .pwm_l_in(l_in),
    .src_a_sel(sa), .src_b_sel(sb), .src_a_inv(ia), .src_b_inv(ib),
    .func_sel(fn), .dest_sel(dst), .pwm_h_out(ha_o), .pwm_l_out(la_o));

  pwm_combo_cell #(.NGEN(8), .INST_ID("B")) uut_lo (
    .clk(clk), .rst_n(rst_n), .pwm_h_in(h_in), .pwm_l_in(l_in),
    .src_a_sel(sa), .src_b_sel(sb), .src_a_inv(ia), .src_b_inv(ib),
    .func_sel(fn), .dest_sel(dst), .pwm_h_out(hb_o), .pwm_l_out(lb_o));

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] a, input logic [3:0] b, input logic xa,
                       input logic xb, input logic [1:0] f, input logic [2:0] d);
    @(negedge clk);
    sa = a; sb = b; ia = xa; ib = xb; fn = f; dst = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  // sa, sb, ia, ib, fn, dst, override, value
  typedef struct packed {
    logic [3:0] a; logic [3:0] b; logic xa; logic xb;
    logic [1:0] f; logic [2:0] d; logic ov; logic v;
  } vec_t;
  localparam int NV = 9;
  // inputs: h=A5, l=3C
  localparam vec_t VT [NV] = '{
    '{4'd0,  4'd1,  1'b0, 1'b0, 2'b00, 3'd3, 1'b1, 1'b1}, // R3 OR 1|0
    '{4'd0,  4'd1,  1'b0, 1'b0, 2'b01, 3'd2, 1'b1, 1'b0}, // R3 AND 1&0
    '{4'd0,  4'd1,  1'b0, 1'b0, 2'b10, 3'd1, 1'b1, 1'b1}, // R3 XOR
    '{4'd0,  4'd1,  1'b0, 1'b1, 2'b01, 3'd4, 1'b1, 1'b1}, // R2 invert b
    '{4'd0,  4'd1,  1'b1, 1'b0, 2'b00, 3'd7, 1'b1, 1'b0}, // R2 invert a
    '{4'd15, 4'd14, 1'b0, 1'b0, 2'b10, 3'd6, 1'b1, 1'b1}, // R1 gen8 L/H
    '{4'd5,  4'd9,  1'b1, 1'b1, 2'b01, 3'd5, 1'b1, 1'b0}, // R2 both
    '{4'd0,  4'd1,  1'b0, 1'b0, 2'b00, 3'd0, 1'b0, 1'b0}, // R4 disabled
    '{4'd0,  4'd1,  1'b0, 1'b0, 2'b11, 3'd4, 1'b0, 1'b0}  // R7 reserved
  };

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    h_in = 8'hFF; l_in = 8'hFF; sa = 0; sb = 0; ia = 0; ib = 0; fn = 0; dst = 3'd1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 reset high bus", {8'h0, ha_o}, 16'h0);
    check("R8 reset low bus", {8'h0, lb_o}, 16'h0);
    rst_n = 1'b1;
    // R8 latency: inputs change after a negedge, output holds until next posedge
    h_in = 8'hA5; l_in = 8'h3C; dst = 3'd0;
    #5;
    check("R8 no change before edge", {ha_o, la_o}, 16'h0000);
    @(posedge clk);
    @(negedge clk);
    check("R8 one-cycle latency", {ha_o, la_o}, 16'hA53C);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] eh, el;
      apply(VT[i].a, VT[i].b, VT[i].xa, VT[i].xb, VT[i].f, VT[i].d);
      eh = 8'hA5; el = 8'h3C;
      if (VT[i].ov) eh[VT[i].d] = VT[i].v;
      check($sformatf("R3/R5 vec %0d high instance", i), {ha_o, la_o}, {eh, 8'h3C});
      el = 8'h3C;
      if (VT[i].ov) el[VT[i].d] = VT[i].v;
      check($sformatf("R6 vec %0d low instance", i), {hb_o, lb_o}, {8'hA5, el});
    end

    // R1: route each source code to destination 1 via OR with itself
    for (int k = 0; k < 16; k++) begin
      logic s;
      logic [7:0] eh;
      apply(k[3:0], k[3:0], 1'b0, 1'b0, 2'b00, 3'd1);
      s = (k % 2 == 0) ? h_in[k/2] : l_in[k/2];
      eh = h_in; eh[1] = s;
      check($sformatf("R1 select code %0d", k), {ha_o, la_o}, {eh, l_in});
    end

    // R5: generator 1 never replaced; walk destinations with a forced 0
    h_in = 8'hFF;
    for (int d = 1; d < 8; d++) begin
      logic [7:0] eh;
      apply(4'd0, 4'd0, 1'b1, 1'b1, 2'b01, d[2:0]);
      eh = 8'hFF; eh[d] = 1'b0;
      check($sformatf("R5 destination %0d", d), {ha_o, la_o}, {eh, l_in});
    end

    // R7 reserved with a result that would be visible
    h_in = 8'h00;
    apply(4'd0, 4'd0, 1'b1, 1'b1, 2'b11, 3'd2);
    check("R7 reserved no override", {ha_o, lb_o}, {8'h00, l_in});
    // R4 disabled while a live function would set a 1
    apply(4'd0, 4'd0, 1'b1, 1'b1, 2'b00, 3'd0);
    check("R4 disabled pass", {ha_o, lb_o}, {8'h00, l_in});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule